// File: doc/BRIEF.md
# Serial ADC Readout Emulator

This block stands in for the digital pins of a 10-bit successive-approximation converter that has a three-wire serial port. A master on the other side lowers an active-low chip select and then supplies a serial clock. The block takes a 10-bit result and two extra low-order bits from a parallel port and sends them out as the converter would. It is meant to feed a link partner or a test environment. No analog stage is modelled.

Chip select and serial clock are asynchronous to the system clock. Each passes through a two-flop synchronizer, and all edge detection runs in the system clock domain. A falling chip select starts an emulated conversion. The serial output is driven low for a fixed number of system clocks. It then goes high, and this high level is both the end-of-conversion flag and the leading 1 of the frame. After that, each falling serial-clock edge presents the next bit: the data from bit 9 down to bit 0, then the two extra bits, then zeros for as long as the clock runs. While chip select is high the output enable is off.

A new conversion needs a minimum chip-select-high time, which counts as acquisition time. A chip-select fall that comes too early is reported on a one-cycle violation pulse and is otherwise ignored.

Top module: `adc_serial_emu`

## Requirements
- R1: After reset, doutOe and timingViol are 0.
- R2: An accepted csN fall sets doutOe to 1 with dout 0, three system clocks after the fall is presented.
- R3: dout stays 0 for exactly CONV_CYCLES system clocks from the cycle in which doutOe rises, and is 1 on the next cycle (end-of-conversion flag and leading 1).
- R4: sclk falling edges during the conversion time have no effect: dout stays 0, and the first sclk fall after the end of conversion still presents data bit 9.
- R5: After the end of conversion, the n-th sclk fall (n = 1..12) puts bit 12-n of the word {sampleData[9:0], sampleSub[1:0]} on dout, three system clocks after the fall is presented. The order is therefore D9 first down to D0, then sub-bit 1, then sub-bit 0.
- R6: Every sclk fall after the twelfth, with csN still low, puts 0 on dout.
- R7: doutOe returns to 0 three system clocks after csN rises, and sclk activity while csN is high leaves doutOe at 0.
- R8: A csN rise during the conversion time aborts it (doutOe goes to 0) and restarts the acquisition timer.
- R9: A csN fall seen fewer than ACQ_CYCLES+1 system clocks after the last csN rise produces a one-cycle pulse on timingViol and starts no conversion (doutOe stays 0 while csN remains low).
- R10: The output word is latched at the accepted csN fall, so changes on sampleData or sampleSub during readout do not change the bits sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select from the master, asynchronous |
| sclk | input | 1 | Serial clock from the master, asynchronous, idles low |
| sampleData | input | DATA_W | Conversion result to send, most significant bit first |
| sampleSub | input | SUB_W | Extra low-order bits sent after the result |
| dout | output | 1 | Serial data value |
| doutOe | output | 1 | Output enable for dout; 0 means the pin is released (high impedance) |
| timingViol | output | 1 | One-cycle pulse on a chip-select fall that came before the acquisition time elapsed |

## Verification
Every result that follows an input change is due three system clocks later: two synchronizer stages, then the registered state and output. The bench changes inputs on a falling clock edge, advances exactly three rising edges, and samples on the next falling edge. Conversion timing is checked at the last low cycle (CONV_CYCLES-1 clocks after doutOe rises) and on the cycle after, so an error of one clock in either direction shows up. For the acquisition rule, a chip-select fall five clocks after a rise must be rejected, and one ACQ_CYCLES+4 clocks after a rise must be accepted.

// File: rtl/emu_pkg.sv
package emu_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_SHIFT = 2'd2
  } emuState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // latch word, drive low
    logic markEoc;  // drive the end-of-conversion high
    logic shift;    // present next bit
  } emuStrobe_t;

endpackage

// File: rtl/emu_sync.sv
module emu_sync #(
  parameter int STAGES = 2,
  parameter bit RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic lvl,
  output logic prevLvl
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain   <= {STAGES{RESET_VAL}};
      prevLvl <= RESET_VAL;
    end else begin
      chain   <= {chain[STAGES-2:0], asyncIn};
      prevLvl <= chain[STAGES-1];
    end
  end

  assign lvl = chain[STAGES-1];
endmodule

// File: rtl/emu_ctrl.sv
module emu_ctrl
  import emu_pkg::*;
#(
  parameter int CONV_CYCLES = 20,
  parameter int ACQ_CYCLES  = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csFall,
  input  logic       csRise,
  input  logic       sclkFall,
  output emuStrobe_t strobe,
  output logic       driveEn,
  output logic       violPulse
);
  localparam int CW = $clog2(CONV_CYCLES + 1);
  localparam int AW = $clog2(ACQ_CYCLES + 1);
  localparam logic [CW-1:0] CONV_LAST = CW'(CONV_CYCLES - 1);
  localparam logic [AW-1:0] ACQ_FULL  = AW'(ACQ_CYCLES);

  emuState_t state, stateNxt;
  logic [CW-1:0] convCnt;
  logic [AW-1:0] acqCnt;
  logic acqDone;

  assign acqDone = (acqCnt == ACQ_FULL);

  always_comb begin
    stateNxt      = state;
    strobe        = '0;
    case (state)
      ST_IDLE: begin
        if (csFall && acqDone) begin
          stateNxt    = ST_CONV;
          strobe.load = 1'b1;
        end
      end
      ST_CONV: begin
        if (csRise) begin
          stateNxt = ST_IDLE;
        end else if (convCnt == CONV_LAST) begin
          stateNxt       = ST_SHIFT;
          strobe.markEoc = 1'b1;
        end
      end
      ST_SHIFT: begin
        if (csRise) stateNxt = ST_IDLE;
        else if (sclkFall) strobe.shift = 1'b1;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      convCnt   <= '0;
      acqCnt    <= ACQ_FULL;
      violPulse <= 1'b0;
    end else begin
      state     <= stateNxt;
      violPulse <= (state == ST_IDLE) && csFall && !acqDone;
      if (strobe.load) convCnt <= '0;
      else if (state == ST_CONV) convCnt <= convCnt + 1'b1;
      if (csRise) acqCnt <= '0;
      else if (!acqDone) acqCnt <= acqCnt + 1'b1;
    end
  end

  assign driveEn = (state != ST_IDLE);
endmodule

// File: rtl/emu_dpath.sv
module emu_dpath
  import emu_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  emuStrobe_t        strobe,
  input  logic [WORD_W-1:0] loadWord,
  output logic              serOut
);
  logic [WORD_W-1:0] shreg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shreg  <= '0;
      serOut <= 1'b0;
    end else if (strobe.load) begin
      shreg  <= loadWord;
      serOut <= 1'b0;
    end else if (strobe.markEoc) begin
      serOut <= 1'b1;
    end else if (strobe.shift) begin
      serOut <= shreg[WORD_W-1];
      shreg  <= {shreg[WORD_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/adc_serial_emu.sv
module adc_serial_emu
  import emu_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int SUB_W       = 2,
  parameter int CONV_CYCLES = 20,
  parameter int ACQ_CYCLES  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic [DATA_W-1:0] sampleData,
  input  logic [SUB_W-1:0]  sampleSub,
  output logic              dout,
  output logic              doutOe,
  output logic              timingViol
);
  localparam int WORD_W = DATA_W + SUB_W;

  logic csLvl, csPrev, sclkLvl, sclkPrev;
  logic csFall, csRise, sclkFall;
  emuStrobe_t strobe;

  emu_sync #(.STAGES(2), .RESET_VAL(1'b1)) uCsSync (
    .clk(clk), .rstN(rstN), .asyncIn(csN), .lvl(csLvl), .prevLvl(csPrev));
  emu_sync #(.STAGES(2), .RESET_VAL(1'b0)) uSclkSync (
    .clk(clk), .rstN(rstN), .asyncIn(sclk), .lvl(sclkLvl), .prevLvl(sclkPrev));

  assign csFall   = csPrev & ~csLvl;
  assign csRise   = ~csPrev & csLvl;
  assign sclkFall = sclkPrev & ~sclkLvl;

  emu_ctrl #(.CONV_CYCLES(CONV_CYCLES), .ACQ_CYCLES(ACQ_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .csFall(csFall), .csRise(csRise),
    .sclkFall(sclkFall), .strobe(strobe), .driveEn(doutOe),
    .violPulse(timingViol));

  emu_dpath #(.WORD_W(WORD_W)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .loadWord({sampleData, sampleSub}), .serOut(dout));
endmodule

// File: rtl/adc_serial_emu_chk.sv
module adc_serial_emu_chk #(
  parameter int CONV_CYCLES = 20
) (
  input logic clk,
  input logic rstN,
  input logic dout,
  input logic doutOe,
  input logic timingViol
);
  localparam int LW = $clog2(CONV_CYCLES + 2);
  localparam logic [LW-1:0] LIM = LW'(CONV_CYCLES);

  // cycles since doutOe went high, saturating one past the conversion time
  logic [LW-1:0] oeCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) oeCnt <= '0;
    else if (!doutOe) oeCnt <= '0;
    else if (oeCnt <= LIM) oeCnt <= oeCnt + 1'b1;
  end

  // R2
  conv_starts_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doutOe) |-> !dout);

  // R3
  conv_hold_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doutOe && oeCnt < LIM) |-> !dout);

  // R3
  eoc_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doutOe && oeCnt == LIM) |-> dout);

  // R9
  viol_no_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    timingViol |-> !doutOe);

  // R9
  viol_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    timingViol |=> !timingViol);
endmodule

bind adc_serial_emu adc_serial_emu_chk #(.CONV_CYCLES(CONV_CYCLES)) uChk (
  .clk(clk), .rstN(rstN), .dout(dout), .doutOe(doutOe),
  .timingViol(timingViol));

// File: tb/tb_adc_serial_emu.sv
module tb_adc_serial_emu;
  localparam int CONV = 20;
  localparam int ACQ  = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b0;
  logic [9:0] sampleData = '0;
  logic [1:0] sampleSub = '0;
  logic dout, doutOe, timingViol;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  adc_serial_emu #(.DATA_W(10), .SUB_W(2), .CONV_CYCLES(CONV), .ACQ_CYCLES(ACQ)) dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sampleData(sampleData),
    .sampleSub(sampleSub), .dout(dout), .doutOe(doutOe), .timingViol(timingViol));

  typedef struct packed {
    logic [9:0] d;
    logic [1:0] s;
    logic [4:0] n;
    logic       noise;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{d: 10'h3FF, s: 2'b11, n: 5'd12, noise: 1'b0},
    '{d: 10'h000, s: 2'b00, n: 5'd12, noise: 1'b0},
    '{d: 10'h2AA, s: 2'b01, n: 5'd15, noise: 1'b1},
    '{d: 10'h155, s: 2'b10, n: 5'd14, noise: 1'b0},
    '{d: 10'h201, s: 2'b10, n: 5'd16, noise: 1'b1}
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic runFrame(input vec_t v);
    logic [11:0] word;
    word = {v.d, v.s};
    sampleData = v.d;
    sampleSub  = v.s;
    csN = 1'b0;
    tick(3);
    check("R2 oe", doutOe, 1);
    check("R2 dout", dout, 0);
    if (v.noise) begin
      sclk = 1'b1; tick(2);
      sclk = 1'b0; tick(CONV - 3);
      check("R4 dout during conv", dout, 0);
    end else begin
      tick(CONV - 1);
      check("R3 last low", dout, 0);
    end
    tick(1);
    check("R3 leading one", dout, 1);
    for (int i = 0; i < int'(v.n); i++) begin
      sclk = 1'b1; tick(2);
      sclk = 1'b0; tick(3);
      if (i == 0) begin
        sampleData = ~v.d;   // R10: must not reach the frame
        sampleSub  = ~v.s;
      end
      if (i < 12) check("R5/R10 bit", dout, word[11 - i]);
      else        check("R6 trailing zero", dout, 0);
    end
    csN = 1'b1;
    tick(3);
    check("R7 oe off", doutOe, 0);
    tick(ACQ + 4);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(3);
    check("R1 oe", doutOe, 0);
    check("R1 viol", timingViol, 0);
    rstN = 1'b1;
    tick(3);
    check("R1 oe after release", doutOe, 0);

    for (int k = 0; k < 5; k++) runFrame(VEC[k]);

    // R7: sclk while csN high
    sclk = 1'b1; tick(2); sclk = 1'b0; tick(3);
    check("R7 sclk while cs high", doutOe, 0);

    // R8: abort during conversion
    csN = 1'b0; tick(3);
    check("R8 started", doutOe, 1);
    tick(5);
    csN = 1'b1; tick(3);
    check("R8 aborted", doutOe, 0);
    // R9: early fall (five clocks after rise)
    tick(2);
    csN = 1'b0; tick(3);
    check("R9 viol pulse", timingViol, 1);
    check("R9 no drive", doutOe, 0);
    tick(1);
    check("R9 pulse ends", timingViol, 0);
    tick(CONV + 4);
    check("R9 no conversion", doutOe, 0);
    csN = 1'b1; tick(ACQ + 4);

    // after acquisition time a frame works again
    runFrame('{d: 10'h0F0, s: 2'b01, n: 5'd13, noise: 1'b0});
    check("R9 no viol on valid", timingViol, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule